// File: doc/BRIEF.md
# Serial Management Frame Master

This block sits on an on-chip register bus and drives a two-wire management link toward PHY devices: a clock line it generates (MDC) and a shared data line (MDIO) that it drives through an output-enable and value pair, with an external pull-up holding the line high whenever nobody drives it. Software programs a clock divisor and a preamble choice in a control register. It then writes a complete 32-bit clause-22 frame into the data register. The block shifts that frame onto the wire exactly as written, most significant bit first.

When the frame is a read, the block stops driving the line at the second turnaround bit. It collects the sixteen data bits the PHY returns and presents them in the low half of the data register. A done flag in the control register tells software when the transaction is over. A build-time parameter picks between the current address split (5-bit device, 5-bit register) and an older one (6-bit device, 4-bit register). In the current layout, a write to register address 0x1F is a page-select write. The block tracks the page it selects.

Top module: `mdio_frame_master`

## Requirements
- R1: Control register (bus address 0) holds the MDC divisor in bits 6:0 and the preamble enable in bit 7, both read back as written. Bit 8 is the read-only done flag. All fields read 0 after reset.
- R2: During a transaction each MDC half period lasts (d+1) system clocks, where d is the divisor and a divisor of 0 counts as 1. MDC rests low while idle.
- R3: With preamble enabled, 32 driven '1' bits precede the frame. With it disabled, the first driven bit is frame bit 31.
- R4: The data register (bus address 1) value is sent bit 31 first down to bit 0. Each bit changes after an MDC falling edge and is stable at the next rising edge.
- R5: For a frame with bit 29 (read) set, MDIO is released from bit 16 onward. Sixteen bits are sampled on MDC rising edges, and reading bus address 1 returns them in bits 15:0, first sampled bit at bit 15.
- R6: A launch clears done. Done sets one MDC period after the last frame bit, so it is visible 2·(d+1)·(P+33) clocks after the launching write edge, where P is 32 or 0 per the preamble.
- R7: A data-register write while a transaction is in progress is ignored.
- R8: While the control register holds zero, a data-register write does not start a transaction.
- R9: A data-register write with bit 30 (start) clear does not start a transaction.
- R10: In the current layout, a completed frame with bit 28 (write) set and bits 22:18 equal to 0x1F sets the page output to frame bits 15:4. Other frames leave the page output unchanged. It reads 0 after reset.
- R11: Outside a transaction the output enable is low, so the line idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_out | output | 1 | Data line drive value |
| mdio_in | input | 1 | Data line as seen on the wire |
| page_sel | output | 12 | Page chosen by the last page-select write |

## Verification
A wrong phase or bit index inside the shifter shows at the ports within one MDC period: a missing or extra preamble bit, a shifted frame on the wire, or an output enable that stays high into the read data. A miscounting divider does not change bit order. It shows up as a done flag that rises a whole number of half periods too early or too late, so the bench measures done latency to the exact clock. A launch that slips past the busy or disabled gating shows either as MDC edges where none are expected, or as a captured frame that mixes two writes.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
    localparam int FRAME_W  = 32;
    localparam int DATA_W   = 16;
    localparam int DIV_W    = 7;
    localparam int PRE_LEN  = 32;
    localparam int PRE_CW   = $clog2(PRE_LEN);
    localparam int IDX_W    = $clog2(FRAME_W);
    localparam int PAGE_W   = 12;
    localparam int PAGE_LSB = 4;
    localparam int BIT_START = 30;
    localparam int BIT_RD    = 29;
    localparam int BIT_WR    = 28;
    localparam int REL_IDX   = 16;

    typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_BITS, PH_TAIL} phase_e;

    function automatic logic is_page_write(input logic [FRAME_W-1:0] f,
                                           input logic legacy);
        logic hit;
        if (legacy) hit = 1'b0;
        else        hit = f[BIT_WR] && (f[22:18] == 5'h1F);
        return hit;
    endfunction
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim       = (div == '0) ? DIV_W'(1) : div;
        gen_d     = gen_q;
        rise_tick = 1'b0;
        fall_tick = 1'b0;
        if (!run) begin
            gen_d = '0;
        end else if (gen_q.cnt == lim) begin
            gen_d.cnt = '0;
            gen_d.lvl = ~gen_q.lvl;
            rise_tick = ~gen_q.lvl;
            fall_tick = gen_q.lvl;
        end else begin
            gen_d.cnt = gen_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign mdc = gen_q.lvl;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import mdio_frame_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               pre_en,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_in,
    output logic               busy,
    output logic               done,
    output logic               finish,
    output logic               mdio_oe,
    output logic               mdio_out,
    output logic [DATA_W-1:0]  rx_data
);
    typedef struct packed {
        phase_e             phase;
        logic [PRE_CW-1:0]  pre_cnt;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] frame;
        logic               is_rd;
        logic               done;
        logic [DATA_W-1:0]  rx;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d  = shf_q;
        finish = 1'b0;
        unique case (shf_q.phase)
            PH_IDLE: begin
                if (launch) begin
                    shf_d.frame   = frame_in;
                    shf_d.is_rd   = frame_in[BIT_RD];
                    shf_d.done    = 1'b0;
                    shf_d.idx     = IDX_W'(FRAME_W - 1);
                    shf_d.pre_cnt = PRE_CW'(PRE_LEN - 1);
                    shf_d.rx      = '0;
                    shf_d.phase   = pre_en ? PH_PRE : PH_BITS;
                end
            end
            PH_PRE: begin
                if (fall_tick) begin
                    if (shf_q.pre_cnt == '0) shf_d.phase = PH_BITS;
                    else shf_d.pre_cnt = shf_q.pre_cnt - PRE_CW'(1);
                end
            end
            PH_BITS: begin
                if (rise_tick && shf_q.is_rd && (shf_q.idx < IDX_W'(REL_IDX)))
                    shf_d.rx = {shf_q.rx[DATA_W-2:0], mdio_in};
                if (fall_tick) begin
                    if (shf_q.idx == '0) shf_d.phase = PH_TAIL;
                    else shf_d.idx = shf_q.idx - IDX_W'(1);
                end
            end
            PH_TAIL: begin
                if (fall_tick) begin
                    shf_d.phase = PH_IDLE;
                    shf_d.done  = 1'b1;
                    finish      = 1'b1;
                end
            end
            default: shf_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign busy     = (shf_q.phase != PH_IDLE);
    assign done     = shf_q.done;
    assign rx_data  = shf_q.rx;
    assign mdio_oe  = (shf_q.phase == PH_PRE) ||
                      ((shf_q.phase == PH_BITS) &&
                       !(shf_q.is_rd && (shf_q.idx <= IDX_W'(REL_IDX))));
    assign mdio_out = (shf_q.phase == PH_BITS) ? shf_q.frame[shf_q.idx] : 1'b1;
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_frame_pkg::*;
#(
    parameter bit LEGACY_LAYOUT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_addr,
    input  logic [FRAME_W-1:0]  reg_wdata,
    output logic [FRAME_W-1:0]  reg_rdata,
    output logic                mdc,
    output logic                mdio_oe,
    output logic                mdio_out,
    input  logic                mdio_in,
    output logic [PAGE_W-1:0]   page_sel
);
    localparam int CTRL_PAD = FRAME_W - DIV_W - 2;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              pre;
        logic              pend;
        logic [PAGE_W-1:0] pend_page;
        logic [PAGE_W-1:0] page;
    } top_t;

    top_t top_d, top_q;
    logic busy, xfer_done, finish, launch, access_on;
    logic rise_tick, fall_tick;
    logic [DATA_W-1:0] rx_data;

    always_comb begin
        top_d     = top_q;
        access_on = (top_q.div != '0) || top_q.pre;
        launch    = reg_wr && reg_addr && reg_wdata[BIT_START] && !busy && access_on;
        if (reg_wr && !reg_addr) begin
            top_d.div = reg_wdata[DIV_W-1:0];
            top_d.pre = reg_wdata[DIV_W];
        end
        if (launch) begin
            top_d.pend      = is_page_write(reg_wdata, LEGACY_LAYOUT);
            top_d.pend_page = reg_wdata[PAGE_LSB +: PAGE_W];
        end
        if (finish && top_q.pend) begin
            top_d.page = top_q.pend_page;
            top_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    mdc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (top_q.div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    frame_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .frame_in  (reg_wdata),
        .pre_en    (top_q.pre),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .done      (xfer_done),
        .finish    (finish),
        .mdio_oe   (mdio_oe),
        .mdio_out  (mdio_out),
        .rx_data   (rx_data)
    );

    assign reg_rdata = reg_addr ? {{(FRAME_W-DATA_W){1'b0}}, rx_data}
                                : {{CTRL_PAD{1'b0}}, xfer_done, top_q.pre, top_q.div};
    assign page_sel  = top_q.page;
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic xfer_done,
    input logic mdc,
    input logic mdio_oe,
    input logic launch,
    input logic access_on
);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_launch_clears_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!xfer_done && busy));

    p_done_at_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> (!busy && !mdc));

    p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !launch) |=> xfer_done);

    p_off_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_on && !busy) |=> !busy);

    p_busy_no_relaunch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |-> !launch);
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .xfer_done (xfer_done),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .launch    (launch),
    .access_on (access_on)
);

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_oe, mdio_out, mdio_in;
    logic [11:0] page_sel;

    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    mdio_frame_master i_mdio_frame_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_oe(mdio_oe), .mdio_out(mdio_out), .mdio_in(mdio_in),
        .page_sel(page_sel)
    );

    // wire monitor and PHY responder
    logic [63:0] cap = '0;
    int cap_n = 0, cap_base = 0;
    int rise_n = 0;
    int fall_n = 0, fall_base = 0;
    int npre_exp = 0;
    logic [15:0] resp_word = '0;
    logic resp_bit;

    always @(posedge mdc) begin
        rise_n = rise_n + 1;
        if (mdio_oe) begin
            cap   = {cap[62:0], mdio_out};
            cap_n = cap_n + 1;
        end
    end
    always @(negedge mdc) fall_n = fall_n + 1;

    always_comb begin
        int k;
        k = fall_n - fall_base - npre_exp;
        resp_bit = (k >= 16 && k <= 31) ? resp_word[31-k] : 1'b1;
    end
    assign mdio_in = mdio_oe ? mdio_out : resp_bit;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = 1'b0;
    endtask

    function automatic logic [31:0] mk_frame(input bit rd, input logic [4:0] dev,
                                             input logic [4:0] ra, input logic [15:0] d);
        return {1'b0, 1'b1, rd, ~rd, dev, ra, 2'b10, d};
    endfunction

    function automatic int exp_cycles(input int div, input bit pre);
        int h;
        h = ((div == 0) ? 1 : div) + 1;
        return 2 * h * ((pre ? 32 : 0) + 33);
    endfunction

    // full transaction with checks; optional busy write after 9 cycles
    task automatic run_frame(input int div, input bit pre, input logic [31:0] fr,
                             input logic [15:0] resp, input bit interject);
        int cyc;
        logic [31:0] v;
        bit rd;
        rd = fr[29];
        bus_wr(1'b0, {24'b0, pre, div[6:0]});
        resp_word = resp;
        npre_exp  = pre ? 32 : 0;
        cap_base  = cap_n;
        fall_base = fall_n;
        bus_wr(1'b1, fr);
        cyc = 0;
        if (interject) begin
            repeat (9) @(posedge clk);
            bus_wr(1'b1, ~fr | 32'h4000_0000);   // R7 write while busy
            cyc = 10;
        end
        while (cyc < 5000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (reg_rdata[8]) break;
        end
        check(cyc == exp_cycles(div, pre), "R6/R2 done latency", cyc, exp_cycles(div, pre));
        if (rd) begin
            check(cap_n - cap_base == npre_exp + 15, "R5 release at bit 16",
                  cap_n - cap_base, npre_exp + 15);
            check(cap[14:0] == fr[31:17], "R4 read header bits", {17'b0, cap[14:0]},
                  {17'b0, fr[31:17]});
            bus_rd(1'b1, v);
            check(v == {16'b0, resp}, "R5 read data", v, {16'b0, resp});
        end else begin
            check(cap_n - cap_base == npre_exp + 32, "R3 driven bit count",
                  cap_n - cap_base, npre_exp + 32);
            check(cap[31:0] == fr, interject ? "R7 frame intact" : "R4 frame order",
                  cap[31:0], fr);
            if (pre)
                check(cap[63:32] == 32'hFFFF_FFFF, "R3 preamble ones", cap[63:32],
                      32'hFFFF_FFFF);
        end
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R11 idle after done", {30'b0, mdc, mdio_oe}, 0);
    endtask

    task automatic expect_no_start(input string req);
        int r0;
        logic [31:0] v;
        r0 = rise_n;
        repeat (40) @(posedge clk);
        @(negedge clk);
        bus_rd(1'b0, v);
        check(rise_n == r0 && v[8] == 1'b1 && mdio_oe == 1'b0, req,
              {v[8], 31'(rise_n - r0)}, 32'h8000_0000);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1D5));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        bus_rd(1'b0, v);
        check(v == 0, "R1 control reset", v, 0);
        check(mdc == 0 && mdio_oe == 0, "R11 idle at reset", {mdc, mdio_oe}, 0);
        check(page_sel == 0, "R10 page reset", {20'b0, page_sel}, 0);

        bus_wr(1'b0, 32'h0000_0085);
        bus_rd(1'b0, v);
        check(v == 32'h0000_0085, "R1 control readback", v, 32'h85);

        run_frame(0, 1'b1, mk_frame(1'b0, 5'h03, 5'h01, 16'hA5C3), 16'h0, 1'b0);
        run_frame(2, 1'b0, mk_frame(1'b1, 5'h11, 5'h02, 16'h0000), 16'h9E17, 1'b0);
        run_frame(1, 1'b1, mk_frame(1'b0, 5'h1E, 5'h06, 16'h1466), 16'h0, 1'b1);

        bus_wr(1'b1, mk_frame(1'b0, 5'h01, 5'h01, 16'h1234) & ~32'h4000_0000);
        expect_no_start("R9 no start bit");

        bus_wr(1'b0, 32'h0);
        bus_wr(1'b1, mk_frame(1'b0, 5'h01, 5'h01, 16'h1234));
        expect_no_start("R8 access off");

        run_frame(1, 1'b0, mk_frame(1'b0, 5'h00, 5'h1F, 16'h0A70), 16'h0, 1'b0);
        check(page_sel == 12'h0A7, "R10 page select", {20'b0, page_sel}, 32'h0A7);
        run_frame(1, 1'b0, mk_frame(1'b0, 5'h00, 5'h04, 16'hFFF0), 16'h0, 1'b0);
        check(page_sel == 12'h0A7, "R10 page kept", {20'b0, page_sel}, 32'h0A7);

        for (int i = 0; i < 6; i++) begin
            int dv;
            bit pr, rd;
            dv = $urandom % 4;
            pr = $urandom % 2;
            rd = $urandom % 2;
            run_frame(dv, pr, mk_frame(rd, 5'($urandom), 5'($urandom % 31),
                      16'($urandom)), 16'($urandom), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule